// File: doc/BRIEF.md
# Programmable Clock Source and Divider Unit

This block produces a divided system clock from one of several candidate clocks. Two 16-bit configuration words are loaded through a plain address/data write port. The divide word holds the output ratio and the feedback ratio. The reference word holds the reference ratio, two power-save enables, the slew code and a three-bit source selector.

The block has three dividers:
- a reference divider that turns crystal rising edges into phase-detector reference ticks;
- a feedback divider that turns VCO rising edges into feedback ticks;
- an output divider that drives the clock output pin from the selected source.

Every clock input is a level that is sampled on the fabric clock `clk`. The dividers count rising edges of those sampled levels. The block can be built as the primary instance or the secondary instance. The two differ only in how the upper source-select codes are decoded.

After reset both words are zero. As a result the output stays low and both tick streams stay quiet until software enables them.

Top module: `clkdiv_top`

## Requirements
- R1: After reset, and until a write enables them, `sys_clk_out`, `ref_tick` and `fb_tick` stay 0, `pll_on` is 0 and `slew_mode` is 0.
- R2: A write with `wr_addr` equal to `PLL_ADDR` loads the divide word, and one with `wr_addr` equal to `REF_ADDR` loads the reference word. Either takes effect on the edge that samples `wr_en`. A write to any other address changes no output or state.
- R3: The output ratio is divide-word bits 15..10, and the field value 0 means 64. For a ratio N of 2 or more, the output is a registered square wave with a period of N source rising edges and a high time of floor(N/2) of them. Each rising source edge advances the output one step on the next `clk` edge.
- R4: With an output ratio of 1, `sys_clk_out` follows the selected source level, delayed by one `clk` register.
- R5: When reference-word bit 13 is 0, `sys_clk_out` is held at 0 and the output count is cleared.
- R6: Any write that hits either register restarts all three dividers from a zero count, with the output low.
- R7: The reference ratio is reference-word bits 8..0, and the value 0 means 512. `ref_tick` is high for one cycle after every N-th crystal rising edge.
- R8: The feedback ratio is divide-word bits 9..0, and the value 0 means 1024. `fb_tick` is high for one cycle after every N-th VCO rising edge.
- R9: When reference-word bit 14 is 0, both tick dividers are idle and cleared, and `pll_on` is 0. Otherwise `pll_on` is 1.
- R10: Source select uses reference-word bits {15,12,11}. The value 0xx picks the crystal, 100 picks the instance's own VCO and 101 picks the main PLL. On the primary instance (INST=0), 11x picks the test clock.
- R11: On the secondary instance (INST=1), select 110 picks the primary's PLL (`peer_pll_in`) and 111 picks the test clock. The codes 0xx, 100 and 101 decode as in R10.
- R12: The slew code in reference-word bits 10..9 maps to `slew_mode` as follows: 00 gives 0 (normal), 01 gives 1 (slow), and 10 or 11 give 2 (fast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| xtal_in | input | 1 | Crystal clock level |
| vco_in | input | 1 | Own PLL VCO clock level |
| main_pll_in | input | 1 | Main PLL clock level |
| peer_pll_in | input | 1 | Other instance's PLL clock level (used when INST=1) |
| test_clk_in | input | 1 | Test clock level |
| sys_clk_out | output | 1 | Divided system clock |
| ref_tick | output | 1 | Reference divider tick |
| fb_tick | output | 1 | Feedback divider tick |
| pll_on | output | 1 | PLL enable state |
| slew_mode | output | 2 | Decoded slew: 0 normal, 1 slow, 2 fast |

## Verification
The bench drives both instance variants side by side. It sets the zero fields, so the 64, 512 and 1024 maximum ratios are exercised. A design that treated zero as zero would stall, and one that treated it as one would run at the source rate. Odd output ratios check the floor(N/2) high time, where an off-by-one shows up as a skewed duty cycle. Mid-count rewrites catch a divider that keeps a stale count and emits a runt pulse. Every select code is stepped on both variants, because the primary and secondary decode 110 differently: a shared table would route the test clock where the peer PLL belongs. Writes to unmapped addresses and the 11 slew code catch loose address or field decoding.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int WORD_W = 16;
  localparam int OUT_W  = 6;
  localparam int FB_W   = 10;
  localparam int REF_W  = 9;

  typedef enum logic [1:0] {
    SLEW_NORMAL = 2'd0,
    SLEW_SLOW   = 2'd1,
    SLEW_FAST   = 2'd2
  } slew_e;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PLL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] REF_ADDR = 8'h11,
  localparam int DW = clkdiv_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     div_word,
  output logic [DW-1:0]     ref_word,
  output logic              restart
);
  logic hit_div, hit_ref;
  assign hit_div = wr_en && (wr_addr == PLL_ADDR);
  assign hit_ref = wr_en && (wr_addr == REF_ADDR);
  assign restart = hit_div || hit_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_word <= '0;
      ref_word <= '0;
    end else begin
      if (hit_div) div_word <= wr_data;
      if (hit_ref) ref_word <= wr_data;
    end
  end

  // R2
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != PLL_ADDR && wr_addr != REF_ADDR)
      |=> ($stable(div_word) && $stable(ref_word)));
endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux #(
  parameter int INST = 0
) (
  input  logic [2:0] sel,
  input  logic       xtal,
  input  logic       own_pll,
  input  logic       main_pll,
  input  logic       peer_pll,
  input  logic       test_clk,
  output logic       picked
);
  localparam bit HAS_PEER = (INST != 0);

  always_comb begin
    if (!sel[2]) begin
      picked = xtal;
    end else begin
      case (sel[1:0])
        2'b00:   picked = own_pll;
        2'b01:   picked = main_pll;
        2'b10:   picked = HAS_PEER ? peer_pll : test_clk;
        default: picked = test_clk;
      endcase
    end
  end
endmodule

// File: rtl/clkdiv_tick_div.sv
module clkdiv_tick_div #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  input  logic         in_lvl,
  output logic         tick
);
  logic         in_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  logic         rise;

  assign last = ratio - 1'b1;
  assign rise = in_lvl && !in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      in_q <= in_lvl;
      if (restart || !en) begin
        cnt_q <= '0;
        tick  <= 1'b0;
      end else if (rise) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          tick  <= 1'b0;
        end
      end else begin
        tick <= 1'b0;
      end
    end
  end

  // R9
  tick_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/clkdiv_out_div.sv
module clkdiv_out_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  input  logic         src_lvl,
  output logic         out
);
  logic         src_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] last;
  logic [W:0]   n_eff;
  logic [W:0]   half;
  logic         rise;
  logic         bypass;

  assign last   = ratio - 1'b1;
  assign n_eff  = {ratio == '0, ratio};
  assign half   = n_eff >> 1;
  assign rise   = src_lvl && !src_q;
  assign bypass = (ratio == {{(W-1){1'b0}}, 1'b1});
  assign cnt_nx = (cnt_q == last) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      cnt_q <= '0;
      out   <= 1'b0;
    end else begin
      src_q <= src_lvl;
      if (restart || !en) begin
        cnt_q <= '0;
        out   <= 1'b0;
      end else if (bypass) begin
        cnt_q <= '0;
        out   <= src_lvl;
      end else if (rise) begin
        cnt_q <= cnt_nx;
        out   <= ({1'b0, cnt_nx} < half);
      end
    end
  end

  // R5
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out);
  // R6
  out_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out && cnt_q == '0));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !restart) |=> cnt_q <= last);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
  parameter int INST   = 0,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PLL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] REF_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              xtal_in,
  input  logic              vco_in,
  input  logic              main_pll_in,
  input  logic              peer_pll_in,
  input  logic              test_clk_in,
  output logic              sys_clk_out,
  output logic              ref_tick,
  output logic              fb_tick,
  output logic              pll_on,
  output logic [1:0]        slew_mode
);
  import clkdiv_pkg::*;

  localparam int OUT_LO = WORD_W - OUT_W;

  logic [WORD_W-1:0] div_word, ref_word;
  logic              restart;
  logic              src_pick;
  logic              out_en;
  logic [2:0]        src_sel;
  slew_e             slew;

  clkdiv_regs #(.ADDR_W(ADDR_W), .PLL_ADDR(PLL_ADDR), .REF_ADDR(REF_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_word(div_word), .ref_word(ref_word), .restart(restart)
  );

  assign pll_on  = ref_word[14];
  assign out_en  = ref_word[13];
  assign src_sel = {ref_word[15], ref_word[12], ref_word[11]};

  clkdiv_src_mux #(.INST(INST)) u_mux (
    .sel(src_sel), .xtal(xtal_in), .own_pll(vco_in), .main_pll(main_pll_in),
    .peer_pll(peer_pll_in), .test_clk(test_clk_in), .picked(src_pick)
  );

  clkdiv_tick_div #(.W(REF_W)) u_ref (
    .clk(clk), .rst(rst), .en(pll_on), .restart(restart),
    .ratio(ref_word[REF_W-1:0]), .in_lvl(xtal_in), .tick(ref_tick)
  );

  clkdiv_tick_div #(.W(FB_W)) u_fb (
    .clk(clk), .rst(rst), .en(pll_on), .restart(restart),
    .ratio(div_word[FB_W-1:0]), .in_lvl(vco_in), .tick(fb_tick)
  );

  clkdiv_out_div #(.W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .en(out_en), .restart(restart),
    .ratio(div_word[WORD_W-1:OUT_LO]), .src_lvl(src_pick), .out(sys_clk_out)
  );

  always_comb begin
    case (ref_word[10:9])
      2'b00:   slew = SLEW_NORMAL;
      2'b01:   slew = SLEW_SLOW;
      default: slew = SLEW_FAST;
    endcase
  end
  assign slew_mode = slew;

  // R12
  slew_code_chk: assert property (@(posedge clk) disable iff (rst)
    slew_mode != 2'd3);
endmodule

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;
  localparam logic [7:0] A_DIV = 8'h10;
  localparam logic [7:0] A_REF = 8'h11;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic xtal = 1'b0, vco = 1'b0, mainp = 1'b0, peer = 1'b0, tst = 1'b0;
  logic [1:0] o_clk, o_ref, o_fb, o_pll;
  logic [1:0] slew0, slew1;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  clkdiv_top #(.INST(0)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xtal_in(xtal), .vco_in(vco), .main_pll_in(mainp), .peer_pll_in(peer),
    .test_clk_in(tst), .sys_clk_out(o_clk[0]), .ref_tick(o_ref[0]),
    .fb_tick(o_fb[0]), .pll_on(o_pll[0]), .slew_mode(slew0));

  clkdiv_top #(.INST(1)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xtal_in(xtal), .vco_in(vco), .main_pll_in(mainp), .peer_pll_in(peer),
    .test_clk_in(tst), .sys_clk_out(o_clk[1]), .ref_tick(o_ref[1]),
    .fb_tick(o_fb[1]), .pll_on(o_pll[1]), .slew_mode(slew1));

  // source levels: periods 4, 2, 6, 8, 10 fabric cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    xtal  <= ((cyc / 2) % 2) == 1;
    vco   <= (cyc % 2) == 1;
    mainp <= ((cyc / 3) % 2) == 1;
    peer  <= ((cyc / 4) % 2) == 1;
    tst   <= ((cyc / 5) % 2) == 1;
  end

  // behavioural reference model
  logic [15:0] m_div [2];
  logic [15:0] m_ref [2];
  int  m_ocnt [2], m_rcnt [2], m_fcnt [2];
  bit  m_out [2], m_rt [2], m_ft [2], m_sq [2];
  bit  m_xq, m_vq;

  function automatic bit pick(int inst, logic [15:0] r);
    if (!r[15]) return xtal;
    if (!r[12]) return r[11] ? mainp : vco;
    if (inst == 0) return tst;
    return r[11] ? tst : peer;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_div[i] = '0; m_ref[i] = '0;
        m_ocnt[i] = 0; m_rcnt[i] = 0; m_fcnt[i] = 0;
        m_out[i] = 0; m_rt[i] = 0; m_ft[i] = 0; m_sq[i] = 0;
      end
      m_xq = 0; m_vq = 0;
    end else begin
      bit hit, xr, vr;
      hit = wr_en && (wr_addr == A_DIV || wr_addr == A_REF);
      xr = xtal && !m_xq;
      vr = vco && !m_vq;
      for (int i = 0; i < 2; i++) begin
        bit s, sr;
        int no, nr, nf;
        s  = pick(i, m_ref[i]);
        sr = s && !m_sq[i];
        no = (m_div[i][15:10] == 0) ? 64 : int'(m_div[i][15:10]);
        nr = (m_ref[i][8:0] == 0) ? 512 : int'(m_ref[i][8:0]);
        nf = (m_div[i][9:0] == 0) ? 1024 : int'(m_div[i][9:0]);
        if (hit || !m_ref[i][13]) begin
          m_ocnt[i] = 0; m_out[i] = 0;
        end else if (no == 1) begin
          m_ocnt[i] = 0; m_out[i] = s;
        end else if (sr) begin
          m_ocnt[i] = (m_ocnt[i] + 1) % no;
          m_out[i] = m_ocnt[i] < (no / 2);
        end
        if (hit || !m_ref[i][14]) begin
          m_rcnt[i] = 0; m_rt[i] = 0; m_fcnt[i] = 0; m_ft[i] = 0;
        end else begin
          m_rt[i] = 0; m_ft[i] = 0;
          if (xr) begin
            m_rcnt[i]++;
            if (m_rcnt[i] == nr) begin m_rcnt[i] = 0; m_rt[i] = 1; end
          end
          if (vr) begin
            m_fcnt[i]++;
            if (m_fcnt[i] == nf) begin m_fcnt[i] = 0; m_ft[i] = 1; end
          end
        end
        m_sq[i] = s;
        if (wr_en && wr_addr == A_DIV) m_div[i] = wr_data;
        if (wr_en && wr_addr == A_REF) m_ref[i] = wr_data;
      end
      m_xq = xtal; m_vq = vco;
    end
  end

  task automatic chk(string rq, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        n_tests++;
        if (o_clk[i] != m_out[i] || o_ref[i] != m_rt[i] || o_fb[i] != m_ft[i]
            || o_pll[i] != m_ref[i][14]) begin
          n_fail++;
          $display("FAIL %s inst%0d: actual clk/ref/fb/pll=%b%b%b%b expected %b%b%b%b (t=%0t)",
                   tag, i, o_clk[i], o_ref[i], o_fb[i], o_pll[i],
                   m_out[i], m_rt[i], m_ft[i], m_ref[i][14], $time);
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    idle(40);
    chk("R1 out", o_clk[0], 0); chk("R1 ref", o_ref[0], 0);
    chk("R1 pll", o_pll[1], 0); chk("R1 slew", slew0, 0);

    tag = "R3 R7 R8";  // out ratio 3, fb ratio 5, ref ratio 7, crystal
    wr(A_DIV, (16'd3 << 10) | 16'd5);
    wr(A_REF, 16'h6000 | 16'd7);
    idle(300);
    wr(A_DIV, (16'd6 << 10) | 16'd2);
    idle(200);

    tag = "R3 R7 R8 zero";
    wr(A_DIV, 16'h0000);
    wr(A_REF, 16'h6000);
    idle(4400);

    tag = "R4 R10 R11";  // ratio 1, own VCO
    wr(A_DIV, (16'd1 << 10) | 16'd3);
    wr(A_REF, 16'hE000 | 16'd3);
    idle(60);
    wr(A_REF, 16'hE800 | 16'd3);  // main
    idle(60);

    tag = "R10 R11";
    wr(A_DIV, (16'd2 << 10) | 16'd3);
    wr(A_REF, 16'hF000 | 16'd3);  // 110
    idle(100);
    wr(A_REF, 16'hF800 | 16'd3);  // 111
    idle(100);
    wr(A_REF, 16'hE000 | 16'd3);  // 100
    idle(60);
    wr(A_REF, 16'h7800 | 16'd3);  // 0xx with low bits set: crystal
    idle(60);

    tag = "R5";
    wr(A_REF, 16'h4000 | 16'd3);
    idle(60);
    chk("R5 out held", o_clk[0], 0);

    tag = "R9";
    wr(A_REF, 16'h2000 | 16'd3);
    idle(60);
    chk("R9 pll", o_pll[1], 0); chk("R9 ref", o_ref[1], 0);

    tag = "R6";
    wr(A_DIV, (16'd5 << 10) | 16'd4);
    wr(A_REF, 16'h6000 | 16'd3);
    for (int k = 0; k < 8; k++) begin
      idle(7 + k);
      wr(A_DIV, (16'd5 << 10) | 16'd4);
      chk("R6 restart low", o_clk[0], 0);
    end
    idle(80);

    tag = "R2";
    wr(8'h55, 16'hFFFF);
    wr(8'h12, 16'h0000);
    idle(80);
    chk("R2 pll kept", o_pll[0], 1);
    chk("R2 slew kept", slew1, 0);

    tag = "R12";
    wr(A_REF, 16'h6000 | 16'h0200 | 16'd3);
    @(negedge clk); chk("R12 slow", slew0, 1);
    wr(A_REF, 16'h6000 | 16'h0400 | 16'd3);
    @(negedge clk); chk("R12 fast 10", slew1, 2);
    wr(A_REF, 16'h6000 | 16'h0600 | 16'd3);
    @(negedge clk); chk("R12 fast 11", slew0, 2);
    wr(A_REF, 16'h6000 | 16'd3);
    @(negedge clk); chk("R12 normal", slew1, 0);
    idle(20);
    finish_run();
  end
endmodule